// File: doc/BRIEF.md
# Split-Section Decade Divider with Force-to-Nine

The block is a four-bit decade divider made of two separate counting sections. Each section has its own count input. The first section is a single toggle stage that produces the least significant output bit. The second section counts modulo five and produces the upper three output bits. Both count inputs are sampled in one system clock. A section advances on a falling edge of its input, that is, when a sample of one is followed by a sample of zero.

The two sections can be chained inside the block. A parameter selects one of three arrangements:
- no link, where both count inputs come from outside;
- BCD, where the toggle bit drives the modulo-five section and the output counts 0 through 9 in binary-coded decimal;
- bi-quinary, where the top output bit drives the toggle stage.

Two pairs of gated control inputs force the output:
- When both inputs of the clear pair are high, the output goes to zero.
- When both inputs of the preset pair are high, the output goes to nine. The preset pair wins over the clear pair.

Either forcing action acts on the output in the cycle it is applied, and it holds the count registers while it stays applied.

Top module: `decade_divider`

## Requirements
- R1: After reset, q_out reads 4'b0000 in every link arrangement.
- R2: q_out[0] inverts once for each high-to-low transition of the low-section count input. A low-to-high transition leaves it unchanged.
- R3: q_out[3:1] steps through 0,1,2,3,4 (as a binary number) on each falling edge of the high-section count input, then returns to 0.
- R4: With no link, an edge on one count input changes only the output bits of its own section.
- R5: When zero_a and zero_b are both high and nine_a, nine_b are not both high, q_out reads 4'b0000 in that same cycle.
- R6: If only one input of a control pair is high, that pair has no effect and counting continues.
- R7: When nine_a and nine_b are both high, q_out reads 4'b1001, whatever the clear pair does.
- R8: Falling count edges that occur while a forcing action is applied are discarded. After release, the output keeps the forced value until the next falling edge.
- R9: In the BCD arrangement, the value 9 is followed by 0. Successive falling edges of the low-section input produce q_out = n mod 10.
- R10: In the bi-quinary arrangement, after n falling edges of the high-section input from zero, q_out[3:1] = n mod 5 and q_out[0] = (n div 5) mod 2.
- R11: In a linked arrangement, the count input that the internal link replaces has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt_a_in | input | 1 | Count input of the toggle (divide-by-2) section |
| cnt_b_in | input | 1 | Count input of the modulo-five section |
| zero_a | input | 1 | Clear pair, first gate input |
| zero_b | input | 1 | Clear pair, second gate input |
| nine_a | input | 1 | Preset pair, first gate input |
| nine_b | input | 1 | Preset pair, second gate input |
| q_out | output | 4 | Count value, bit 3 is the top of the modulo-five section, bit 0 the toggle bit |

## Verification
The clear action and the preset action can be requested in the same cycle. A falling count edge can also coincide with either one. The bench raises both full pairs together and expects nine. It then toggles every count input while the forcing stays applied and releases both pairs at once, expecting the forced value to remain. A single input of a pair is also raised alongside a count edge, and the bench expects the count to go on normally.

// File: rtl/decdiv_pkg.sv
`timescale 1ns/1ps
package decdiv_pkg;

    typedef enum logic [1:0] {
        LINK_NONE      = 2'd0,
        LINK_BCD       = 2'd1,
        LINK_BIQUINARY = 2'd2
    } link_e;

    typedef enum logic [1:0] {
        FORCE_NONE = 2'd0,
        FORCE_ZERO = 2'd1,
        FORCE_NINE = 2'd2
    } force_e;

    localparam int QUIN_W = 3;
    localparam int OUT_W  = QUIN_W + 1;
    localparam logic [QUIN_W-1:0] QUIN_LAST = 3'd4;

    typedef struct packed {
        logic [QUIN_W-1:0] quin;
        logic              tog;
    } cnt_state_t;

    localparam cnt_state_t STATE_NINE = '{quin: 3'b100, tog: 1'b1};

endpackage

// File: rtl/decdiv_fall.sv
`timescale 1ns/1ps
module decdiv_fall #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic fall
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], din};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign fall = sh_q[STAGES-1] & ~sh_q[STAGES-2];
endmodule

// File: rtl/decdiv_quinary.sv
`timescale 1ns/1ps
module decdiv_quinary
    import decdiv_pkg::*;
(
    input  logic [QUIN_W-1:0] cur,
    input  logic              adv,
    output logic [QUIN_W-1:0] nxt
);
    always_comb begin
        nxt = cur;
        if (adv) begin
            if (cur < QUIN_LAST) nxt = cur + 1'b1;
            else                 nxt = '0;   // wrap, and recovery from 5..7
        end
    end
endmodule

// File: rtl/decdiv_force.sv
`timescale 1ns/1ps
module decdiv_force
    import decdiv_pkg::*;
(
    input  logic   zero_a,
    input  logic   zero_b,
    input  logic   nine_a,
    input  logic   nine_b,
    output force_e kind
);
    always_comb begin
        if (nine_a && nine_b)      kind = FORCE_NINE;
        else if (zero_a && zero_b) kind = FORCE_ZERO;
        else                       kind = FORCE_NONE;
    end
endmodule

// File: rtl/decade_divider.sv
`timescale 1ns/1ps
module decade_divider
    import decdiv_pkg::*;
#(
    parameter link_e LINK_MODE   = LINK_NONE,
    parameter int    SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_a_in,
    input  logic             cnt_b_in,
    input  logic             zero_a,
    input  logic             zero_b,
    input  logic             nine_a,
    input  logic             nine_b,
    output logic [OUT_W-1:0] q_out
);
    cnt_state_t        st_d, st_q;
    logic              src_a, src_b;
    logic              fall_a, fall_b;
    logic [QUIN_W-1:0] quin_nxt;
    force_e            fkind;

    generate
        if (LINK_MODE == LINK_BIQUINARY) begin : g_src_a_link
            assign src_a = st_q.quin[QUIN_W-1];
        end else begin : g_src_a_pin
            assign src_a = cnt_a_in;
        end
        if (LINK_MODE == LINK_BCD) begin : g_src_b_link
            assign src_b = st_q.tog;
        end else begin : g_src_b_pin
            assign src_b = cnt_b_in;
        end
    endgenerate

    decdiv_fall #(.STAGES(SYNC_STAGES)) i_fall_a (
        .clk(clk), .rst_n(rst_n), .din(src_a), .fall(fall_a)
    );
    decdiv_fall #(.STAGES(SYNC_STAGES)) i_fall_b (
        .clk(clk), .rst_n(rst_n), .din(src_b), .fall(fall_b)
    );

    decdiv_quinary i_quin (
        .cur(st_q.quin), .adv(fall_b), .nxt(quin_nxt)
    );

    decdiv_force i_force (
        .zero_a(zero_a), .zero_b(zero_b),
        .nine_a(nine_a), .nine_b(nine_b),
        .kind(fkind)
    );

    always_comb begin
        st_d = st_q;
        case (fkind)
            FORCE_NINE: st_d = STATE_NINE;
            FORCE_ZERO: st_d = '0;
            default: begin
                if (fall_a) st_d.tog = ~st_q.tog;
                st_d.quin = quin_nxt;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        case (fkind)
            FORCE_NINE: q_out = STATE_NINE;
            FORCE_ZERO: q_out = '0;
            default:    q_out = st_q;
        endcase
    end
endmodule

// File: rtl/decdiv_checker.sv
`timescale 1ns/1ps
module decdiv_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       zero_a,
    input logic       zero_b,
    input logic       nine_a,
    input logic       nine_b,
    input logic [3:0] q_out
);
    logic zero_full, nine_full;
    assign zero_full = zero_a && zero_b;
    assign nine_full = nine_a && nine_b;

    p_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (zero_full && !nine_full) |-> (q_out == 4'b0000));

    p_nine_r7: assert property (@(posedge clk) disable iff (!rst_n)
        nine_full |-> (q_out == 4'b1001));

    p_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
        q_out[3:1] <= 3'd4);

    p_hold_nine_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(nine_full) && !nine_full && !zero_full) |-> (q_out == 4'b1001));

    p_hold_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(zero_full && !nine_full) && !nine_full && !zero_full)
            |-> (q_out == 4'b0000));
endmodule

bind decade_divider decdiv_checker i_decdiv_checker (
    .clk(clk), .rst_n(rst_n),
    .zero_a(zero_a), .zero_b(zero_b),
    .nine_a(nine_a), .nine_b(nine_b),
    .q_out(q_out)
);

// File: tb/test_decade_divider.sv
`timescale 1ns/1ps
module test_decade_divider;
    import decdiv_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [5:0] cin = '0;   // 0:a/none 1:b/none 2:a/bcd 3:b/bcd 4:b/biq 5:a/biq
    logic za = 0, zb = 0, na = 0, nb = 0;
    logic [3:0] q0, q1, q2;
    int total = 0, fails = 0;
    bit done = 0;

    always #2 clk = ~clk;

    decade_divider #(.LINK_MODE(LINK_NONE)) i_decade_divider (
        .clk(clk), .rst_n(rst_n), .cnt_a_in(cin[0]), .cnt_b_in(cin[1]),
        .zero_a(za), .zero_b(zb), .nine_a(na), .nine_b(nb), .q_out(q0));
    decade_divider #(.LINK_MODE(LINK_BCD)) i_decade_divider_bcd (
        .clk(clk), .rst_n(rst_n), .cnt_a_in(cin[2]), .cnt_b_in(cin[3]),
        .zero_a(za), .zero_b(zb), .nine_a(na), .nine_b(nb), .q_out(q1));
    decade_divider #(.LINK_MODE(LINK_BIQUINARY)) i_decade_divider_biq (
        .clk(clk), .rst_n(rst_n), .cnt_a_in(cin[5]), .cnt_b_in(cin[4]),
        .zero_a(za), .zero_b(zb), .nine_a(na), .nine_b(nb), .q_out(q2));

    task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %b expected %b", tag, act, exp);
        end
    endtask

    task automatic settle();
        repeat (8) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic pulse(input int i);
        cin[i] = 1'b1; settle();
        cin[i] = 1'b0; settle();
    endtask

    initial begin
        #800000;
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        int ea, eb;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        settle();
        chk("R1 none", q0, 4'd0);
        chk("R1 bcd",  q1, 4'd0);
        chk("R1 biq",  q2, 4'd0);

        // R2 / R4: toggle section, rising edge then falling edge
        ea = 0; eb = 0;
        for (int i = 0; i < 10; i++) begin
            cin[0] = 1'b1; settle();
            chk("R2 rising edge", q0, {3'(eb % 5), 1'(ea % 2)});
            cin[0] = 1'b0; settle();
            ea++;
            chk("R2 falling edge", q0, {3'(eb % 5), 1'(ea % 2)});
        end
        // R3 / R4: modulo-five section with wrap
        for (int j = 0; j < 12; j++) begin
            pulse(1);
            eb++;
            chk("R3 quinary step", q0[3:1], 4'(eb % 5));
            chk("R4 toggle bit untouched", {3'b0, q0[0]}, {3'b0, 1'(ea % 2)});
        end

        // R5: clear in the same cycle, R8: edges ignored during it
        za = 1; zb = 1; #1;
        chk("R5 clear same cycle", q0, 4'd0);
        pulse(0); pulse(1); pulse(2); pulse(4);
        chk("R8 edges ignored under clear", q0, 4'd0);
        chk("R8 bcd under clear", q1, 4'd0);
        za = 0; zb = 0; settle();
        chk("R8 zero held after release", q0, 4'd0);

        // R6: only one input of each pair high
        za = 1; nb = 1;
        pulse(0);
        chk("R6 partial pairs count", q0, 4'b0001);
        pulse(1);
        chk("R6 partial pairs count b", q0, 4'b0011);
        za = 0; nb = 0;
        pulse(0);
        chk("R6 after partial", q0, 4'b0010);

        // R7: preset over clear, R8: edges ignored during it
        za = 1; zb = 1; na = 1; nb = 1; #1;
        chk("R7 nine over clear", q0, 4'b1001);
        chk("R7 nine bcd", q1, 4'b1001);
        chk("R7 nine biq", q2, 4'b1001);
        pulse(0); pulse(1); pulse(2); pulse(4);
        chk("R8 edges ignored under nine", q0, 4'b1001);
        za = 0; zb = 0; na = 0; nb = 0; settle();
        chk("R8 nine held none", q0, 4'b1001);
        chk("R8 nine held bcd", q1, 4'b1001);
        chk("R8 nine held biq", q2, 4'b1001);
        pulse(1);
        chk("R3 wrap from four", q0, 4'b0001);

        // R9: BCD arrangement
        pulse(2);
        chk("R9 nine to zero", q1, 4'd0);
        for (int n = 1; n < 20; n++) begin
            pulse(2);
            chk("R9 bcd count", q1, 4'(n % 10));
        end
        pulse(3);
        chk("R11 bcd ignores b input", q1, 4'd9);

        // R10: bi-quinary arrangement, starting from nine
        pulse(4);
        chk("R10 nine to zero", q2, 4'd0);
        for (int n = 1; n < 20; n++) begin
            pulse(4);
            chk("R10 biquinary count", q2, {3'(n % 5), 1'((n / 5) % 2)});
        end
        pulse(5);
        chk("R11 biq ignores a input", q2, {3'd4, 1'b1});

        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule